// File: doc/BRIEF.md
# Signed-Digit Minimal Recoder

This block takes a W-bit two's complement fraction and rewrites it as a string of W signed digits, each -1, 0 or +1. The result has the same value as the input, and no two neighbouring digits are both nonzero. That form is the unique one with the fewest nonzero digits. A shift-and-add constant multiplier can therefore use it to cut its adder count.

The recoder works as a single chain from the least significant bit upward. At each position it compares the bit with the one below it. A running flag marks whether the previous position already produced a nonzero digit. A digit is emitted only where the bits differ and the flag is clear. Its sign is taken from the bit one place higher, and the msb is repeated above the top of the word. The chain is combinational. A word presented with its valid strobe is converted and captured in one clock edge.

Top module: `csd_recoder`

## Requirements
- R1: While rst_n is low, out_valid, out_nz and out_neg are all zero.
- R2: out_valid is high in the cycle after a rising clock edge at which in_valid was high, and low otherwise. The digits shown with it are those of the word sampled at that edge.
- R3: With digit i weighted by +2^i for every i, including W-1, the weighted sum of the output digits equals the input word read as a signed integer.
- R4: Two adjacent output digits are never both nonzero.
- R5: Digit i is encoded on out_nz[i] and out_neg[i] as follows: 00 means zero, 10 means +1 and 11 means -1. The pattern 01 never appears.
- R6: An edge at which in_valid is low leaves out_nz and out_neg unchanged.
- R7: The input 8'h80 yields a single -1 at position 7. The input 8'h7F yields +1 at position 7 and -1 at position 0. The input 8'h55 yields +1 at positions 0, 2, 4 and 6.
- R8: With W = 9, the input 9'b1_0111_0011 gives out_nz = 9'h095 and out_neg = 9'h091. Reading from position 8 down, the digits are 0,-1,0,0,-1,0,+1,0,-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | W | Two's complement input word |
| out_valid | output | 1 | Output digits strobe |
| out_nz | output | W | Per-digit nonzero flag |
| out_neg | output | W | Per-digit sign, 1 for -1 |

## Verification
The bench builds the recoder twice, once with W = 8 and once with W = 9. The W = 8 copy is small enough to sweep all 256 input words. That sweep reaches every carry pattern of the flag chain, including the sign-extension case at the top digit, and each result is checked for correct value and for the no-neighbours rule. The W = 9 copy carries the odd-width fixed vector, with exact digits expected at every position.

// File: rtl/csd_recoder.sv
module csd_recoder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  output logic [W-1:0] out_nz,
  output logic [W-1:0] out_neg
);

  localparam int VW = W + 2;

  logic [W-1:0] below, above, diff, flag, neg_d;

  assign below = {in_word[W-2:0], 1'b0};
  assign above = {in_word[W-1], in_word[W-1:1]};
  assign diff  = in_word ^ below;

  assign flag[0] = diff[0];
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign flag[i] = diff[i] & ~flag[i-1];
  end

  assign neg_d = flag & above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_nz    <= '0;
      out_neg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_nz  <= flag;
        out_neg <= neg_d;
      end
    end
  end

  function automatic logic signed [VW-1:0] digit_sum(input logic [W-1:0] nz, input logic [W-1:0] ng);
    logic signed [VW-1:0] acc;
    acc = '0;
    for (int k = 0; k < W; k++) begin
      if (nz[k]) acc = ng[k] ? acc - (VW'(1) <<< k) : acc + (VW'(1) <<< k);
    end
    return acc;
  endfunction

  function automatic logic signed [VW-1:0] word_val(input logic [W-1:0] w);
    return {{2{w[W-1]}}, w};
  endfunction

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (digit_sum(out_nz, out_neg) == word_val($past(in_word))));
  a_r4_no_neighbours: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_nz & (out_nz >> 1)) == '0));
  a_r5_no_code01: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_neg & ~out_nz) == '0));
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_nz) && $stable(out_neg)));

endmodule

// File: tb/csd_recoder_tb_top.sv
module csd_recoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv8 = 1'b0, iv9 = 1'b0;
  logic [7:0] iw8 = '0;
  logic [8:0] iw9 = '0;
  logic ov8, ov9;
  logic [7:0] nz8, ng8;
  logic [8:0] nz9, ng9;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  csd_recoder #(.W(8)) dut_i (.clk(clk), .rst_n(rst_n), .in_valid(iv8), .in_word(iw8),
    .out_valid(ov8), .out_nz(nz8), .out_neg(ng8));
  csd_recoder #(.W(9)) dut9_i (.clk(clk), .rst_n(rst_n), .in_valid(iv9), .in_word(iw9),
    .out_valid(ov9), .out_nz(nz9), .out_neg(ng9));

  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00},
    {8'h7F, 8'h81, 8'h01},
    {8'h80, 8'h80, 8'h80},
    {8'hFF, 8'h01, 8'h01},
    {8'h55, 8'h55, 8'h00},
    {8'h03, 8'h05, 8'h01},
    {8'h60, 8'hA0, 8'h20}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sum8(input logic [7:0] nz, input logic [7:0] ng);
    int s = 0;
    for (int k = 0; k < 8; k++) if (nz[k]) s += ng[k] ? -(1 << k) : (1 << k);
    return s;
  endfunction

  task automatic apply8(input logic [7:0] v);
    @(negedge clk); iv8 = 1'b1; iw8 = v;
    @(negedge clk); iv8 = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ov8 && nz8 == 0 && ng8 == 0, "R1 reset state", {ov8, nz8, ng8}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      apply8(VEC[n][23:16]);
      chk(ov8, "R2 valid after strobe", ov8, 1);
      chk(nz8 == VEC[n][15:8] && ng8 == VEC[n][7:0], "R7 table digits",
          {nz8, ng8}, VEC[n][15:0]);
    end

    for (int v = 0; v < 256; v++) begin
      apply8(8'(v));
      chk(sum8(nz8, ng8) == int'($signed(8'(v))), "R3 weighted sum",
          sum8(nz8, ng8), int'($signed(8'(v))));
      chk((nz8 & (nz8 >> 1)) == 0, "R4 adjacent nonzero", nz8, 0);
      chk((ng8 & ~nz8) == 0, "R5 code 01 seen", ng8, nz8);
    end

    apply8(8'h03);
    @(negedge clk); iw8 = 8'hC4;
    @(negedge clk);
    chk(!ov8, "R2 valid drops", ov8, 0);
    chk(nz8 == 8'h05 && ng8 == 8'h01, "R6 hold while idle", {nz8, ng8}, 16'h0501);

    @(negedge clk); iv9 = 1'b1; iw9 = 9'b1_0111_0011;
    @(negedge clk); iv9 = 1'b0;
    chk(ov9 && nz9 == 9'h095 && ng9 == 9'h091, "R8 nine-bit vector",
        {nz9, ng9}, {9'h095, 9'h091});

    rst_n = 1'b0;
    @(negedge clk);
    chk(!ov9 && nz9 == 0 && ng9 == 0 && nz8 == 0, "R1 reset clears", {nz9, ng9}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule